// File: doc/BRIEF.md
# Single-Operand Read-Modify-Write Unit

This block carries out the one-operand operations of a small accumulator CPU. These are two's-complement negation, bitwise inversion, a test against zero, clear, increment, decrement, and five shift and rotate forms. The controller presents an operation code and an 8-bit operand together with the CPU's current carry, and pulses `start`. On the next clock edge the unit registers the result and the new negative, zero and carry flags, and raises `done` for one cycle.

Each operation has its own carry rule. Negation reports a borrow. Inversion forces carry high. The shifts and rotates capture the bit that leaves the word. Clear, increment, decrement and test pass the incoming carry through unchanged. Rotates feed the incoming carry into the bit position that the shift empties. Codes outside the defined set leave the result and flag registers untouched.

Top module: `rmw_unit`

## Requirements
- R1: `done` is high in the cycle after `start` was sampled high, and low in the cycle after `start` was sampled low. Result and flags change only on an edge where `start` is high.
- R2: The operation code is 4 bits: 0 negate, 1 complement, 2 test, 3 clear, 4 increment, 5 decrement, 6 logical shift left, 7 rotate left, 8 arithmetic shift right, 9 logical shift right, 10 rotate right.
- R3: Negate (code 0) returns 0 minus the operand, and C is 1 exactly when that subtraction borrows, that is, when the operand is non-zero.
- R4: Complement (code 1) returns the bitwise inverse of the operand, and C is always 1.
- R5: Test (code 2) presents the operand unchanged on `result`. N and Z are taken from 0 minus the operand, and C equals `carry_in`.
- R6: Clear (code 3) returns 0. Increment (code 4) returns operand+1 modulo 256. Decrement (code 5) returns operand−1 modulo 256. All three set C equal to `carry_in`.
- R7: Logical shift left (code 6) puts 0 in bit 0. Rotate left (code 7) puts `carry_in` in bit 0. Both load C from operand bit 7.
- R8: Arithmetic shift right (code 8) keeps bit 7. Logical shift right (code 9) puts 0 in bit 7. Rotate right (code 10) puts `carry_in` in bit 7. All three load C from operand bit 0.
- R9: For every code except test, N equals result bit 7, and Z is 1 exactly when all 8 result bits are 0.
- R10: Codes 11 to 15 leave `result`, N, Z and C holding their previous values, but `done` still pulses.
- R11: A synchronous active-high reset clears `result`, all three flags and `done` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation request, sampled on the rising edge |
| op | input | 4 | Operation code (R2) |
| operand | input | 8 | Value to operate on |
| carry_in | input | 1 | Current carry flag of the CPU |
| result | output | 8 | Registered result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
All outputs of this block are due exactly one rising edge after the inputs are sampled. The result, the three flags and the `done` pulse share that single register stage. The bench applies a new request at each falling edge. An untimed reference model advances at every rising edge, and the bench compares every output with the model at the next falling edge, before it drives the next request. Requests alternate with idle cycles, unknown codes and a mid-run reset, so the held values and the one-cycle `done` width are checked as well as the computed results.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NEG = 4'd0,
    OP_COM = 4'd1,
    OP_TST = 4'd2,
    OP_CLR = 4'd3,
    OP_INC = 4'd4,
    OP_DEC = 4'd5,
    OP_LSL = 4'd6,
    OP_ROL = 4'd7,
    OP_ASR = 4'd8,
    OP_LSR = 4'd9,
    OP_ROR = 4'd10
  } rmw_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd10;

endpackage

// File: rtl/rmw_arith.sv
module rmw_arith
  import rmw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    operand,
  input  logic            carry_in,
  output logic            hit,
  output logic [W-1:0]    value,
  output logic [W-1:0]    flag_src,
  output logic            carry_out
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W:0] neg_ext;

  always_comb neg_ext = {1'b0, {W{1'b0}}} - {1'b0, operand};

  always_comb begin
    hit       = 1'b1;
    value     = operand;
    flag_src  = operand;
    carry_out = carry_in;
    case (rmw_op_e'(op))
      OP_NEG: begin
        value     = neg_ext[W-1:0];
        flag_src  = neg_ext[W-1:0];
        carry_out = neg_ext[W];
      end
      OP_COM: begin
        value     = ~operand;
        flag_src  = ~operand;
        carry_out = 1'b1;
      end
      OP_TST: begin
        value     = operand;
        flag_src  = neg_ext[W-1:0];
      end
      OP_CLR: begin
        value     = '0;
        flag_src  = '0;
      end
      OP_INC: begin
        value     = operand + ONE;
        flag_src  = operand + ONE;
      end
      OP_DEC: begin
        value     = operand - ONE;
        flag_src  = operand - ONE;
      end
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/rmw_shifter.sv
module rmw_shifter
  import rmw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    operand,
  input  logic            carry_in,
  output logic            hit,
  output logic [W-1:0]    value,
  output logic            carry_out
);

  logic left;
  logic fill;

  always_comb begin
    hit  = 1'b1;
    left = 1'b0;
    fill = 1'b0;
    case (rmw_op_e'(op))
      OP_LSL: begin left = 1'b1; fill = 1'b0;           end
      OP_ROL: begin left = 1'b1; fill = carry_in;       end
      OP_ASR: begin left = 1'b0; fill = operand[W-1];   end
      OP_LSR: begin left = 1'b0; fill = 1'b0;           end
      OP_ROR: begin left = 1'b0; fill = carry_in;       end
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    if (left) begin
      value     = {operand[W-2:0], fill};
      carry_out = operand[W-1];
    end else begin
      value     = {fill, operand[W-1:1]};
      carry_out = operand[0];
    end
  end

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    operand,
  input  logic            carry_in,
  output logic [W-1:0]    result,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            done
);

  logic         ar_hit, sh_hit;
  logic [W-1:0] ar_val, ar_flag, sh_val;
  logic         ar_c, sh_c;

  rmw_arith #(.W(W)) arith_i (
    .op(op), .operand(operand), .carry_in(carry_in),
    .hit(ar_hit), .value(ar_val), .flag_src(ar_flag), .carry_out(ar_c)
  );

  rmw_shifter #(.W(W)) shift_i (
    .op(op), .operand(operand), .carry_in(carry_in),
    .hit(sh_hit), .value(sh_val), .carry_out(sh_c)
  );

  logic         nxt_hit;
  logic [W-1:0] nxt_val, nxt_flag;
  logic         nxt_c;

  always_comb begin
    nxt_hit  = ar_hit | sh_hit;
    nxt_val  = sh_hit ? sh_val : ar_val;
    nxt_flag = sh_hit ? sh_val : ar_flag;
    nxt_c    = sh_hit ? sh_c   : ar_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start && nxt_hit) begin
        result <= nxt_val;
        flag_n <= nxt_flag[W-1];
        flag_z <= (nxt_flag == '0);
        flag_c <= nxt_c;
      end
    end
  end

  // R1: done follows start by exactly one edge
  a_r1_done_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result) && $stable(flag_c));

  // R4: complement forces carry high
  a_r4_com_carry: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_COM) |=> flag_c);

  // R6: clear gives zero with carry passed through
  a_r6_clr_zero: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_CLR) |=> (result == '0) && flag_z && !flag_n
                                && (flag_c == $past(carry_in)));

  // R7: rotate left feeds old carry into bit 0 and old bit 7 into carry
  a_r7_rol_bits: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_ROL) |=> (result[0] == $past(carry_in))
                                && (flag_c == $past(operand[W-1])));

  // R8: rotate right feeds old carry into bit 7 and old bit 0 into carry
  a_r8_ror_bits: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_ROR) |=> (result[W-1] == $past(carry_in))
                                && (flag_c == $past(operand[0])));

  // R9: N and Z describe the stored result for all codes but test
  a_r9_nz_match: assert property (@(posedge clk) disable iff (rst)
    (start && op != OP_TST && op <= OP_LAST) |=>
      (flag_z == (result == '0)) && (flag_n == result[W-1]));

  // R10: unknown codes keep the previous state
  a_r10_unknown_hold: assert property (@(posedge clk) disable iff (rst)
    (start && op > OP_LAST) |=> $stable(result) && $stable(flag_n)
                                && $stable(flag_z) && $stable(flag_c));

  // R11: reset clears the outputs
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0) && !done && !flag_n && !flag_z && !flag_c);

endmodule

// File: tb/rmw_unit_tb.sv
module rmw_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] operand = 8'd0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       flag_n, flag_z, flag_c, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmw_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .operand(operand),
    .carry_in(carry_in), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .done(done)
  );

  // Reference model state
  int  m_res = 0;
  bit  m_n = 0, m_z = 0, m_c = 0, m_done = 0;
  int  m_op = 0;
  bit  m_rst = 1;

  always @(posedge clk) begin
    int x, ci, r, fsrc, c;
    bit ok;
    m_rst = rst;
    m_op  = op;
    if (rst) begin
      m_res = 0; m_n = 0; m_z = 0; m_c = 0; m_done = 0;
    end else begin
      m_done = start;
      if (start) begin
        x = operand; ci = carry_in; ok = 1; c = ci;
        r = 0; fsrc = 0;
        case (op)
          0:  begin r = (256 - x) % 256; fsrc = r; c = (x != 0); end
          1:  begin r = 255 - x; fsrc = r; c = 1; end
          2:  begin r = x; fsrc = (256 - x) % 256; end
          3:  begin r = 0; fsrc = 0; end
          4:  begin r = (x + 1) % 256; fsrc = r; end
          5:  begin r = (x + 255) % 256; fsrc = r; end
          6:  begin r = (x * 2) % 256; fsrc = r; c = x / 128; end
          7:  begin r = (x * 2) % 256 + ci; fsrc = r; c = x / 128; end
          8:  begin r = x / 2 + (x / 128) * 128; fsrc = r; c = x % 2; end
          9:  begin r = x / 2; fsrc = r; c = x % 2; end
          10: begin r = x / 2 + ci * 128; fsrc = r; c = x % 2; end
          default: ok = 0;
        endcase
        if (ok) begin
          m_res = r; m_n = (fsrc >= 128); m_z = (fsrc == 0); m_c = c[0];
        end
      end
    end
  end

  function automatic string tag_of(int o, bit was_rst);
    if (was_rst) return "R11";
    case (o)
      0: return "R3";  1: return "R4";  2: return "R5";
      3, 4, 5: return "R6";
      6, 7: return "R7";
      8, 9, 10: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check_field(string name, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Compare every output against the model; called at falling edges
  task automatic compare_all();
    string t;
    t = tag_of(m_op, m_rst);
    check_field("done (R1)", m_rst ? "R11" : "R1", done, m_done);
    check_field("result", t, result, m_res);
    check_field("flag_n (R9)", t, flag_n, m_n);
    check_field("flag_z (R9)", t, flag_z, m_z);
    check_field("flag_c", t, flag_c, m_c);
  endtask

  task automatic step(bit s, int o, int x, bit ci);
    @(negedge clk);
    compare_all();
    start = s; op = 4'(o); operand = 8'(x); carry_in = ci;
  endtask

  int vals[8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'hFE};

  initial begin : main
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R11: reset state
    compare_all();
    rst = 1'b0;
    // R2 encoding sweep across all codes, operands and carries
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int ci = 0; ci < 2; ci++) begin
          step(1'b1, o, vals[i], ci[0]);
          if ((i + ci) % 3 == 0) step(1'b0, (o + 3) % 16, vals[7 - i], ~ci[0]);
        end
    // R10: unknown code right after a flag-setting op
    step(1'b1, 1, 8'h00, 1'b0);
    step(1'b1, 13, 8'h80, 1'b1);
    step(1'b1, 15, 8'h01, 1'b0);
    step(1'b0, 0, 8'h00, 1'b0);
    // R3 boundary: negate of 0x80 and 0x00
    step(1'b1, 0, 8'h80, 1'b0);
    step(1'b1, 0, 8'h00, 1'b1);
    // R5: test of 0x01 gives N=1 with result unchanged
    step(1'b1, 2, 8'h01, 1'b1);
    // R11: mid-run reset
    step(1'b1, 4, 8'hFF, 1'b1);
    @(negedge clk);
    compare_all();
    rst = 1'b1; start = 1'b1; op = 4'd1;
    @(negedge clk);
    compare_all();
    rst = 1'b0; start = 1'b0;
    step(1'b1, 5, 8'h00, 1'b0);
    step(1'b0, 0, 8'h00, 1'b0);
    step(1'b0, 0, 8'h00, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule